// File: doc/BRIEF.md
# Multibank Row-Register DRAM Cache

This block models a DRAM whose array carries its own cache. The storage is split into independent banks. Each bank owns an SRAM row register that holds one complete row, and a tag latch that remembers which row the register holds. A read compares its row address against the tag of the bank it selects. On a match (hit) the word comes out of the row register on the next cycle. On a mismatch (miss) the whole row is pulled from the behavioural array into the register in a single wide transfer, and the tag is updated. The word is then returned, three cycles after the request. Reads are never served straight from the array.

Writes are absorbed by a one-entry posting register and finish in one cycle whether or not their row is cached. If the target row sits in its bank's row register, that word is patched in place at acceptance. The posting register then drains to the array on the following edge, so the cache and the array never disagree. A refresh pulse input queues one refresh. A refresh address counter walks through all rows of all banks, and each refresh holds the array for a fixed number of cycles. Hit reads keep running during a refresh. A refresh never starts while a row fill is in flight, and a fill that finds a refresh running waits for it to end.

Requests and responses are valid/ready streams. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a miss fill is in flight. It is also low while a response is waiting and `rsp_ready` is low, so one read is outstanding at a time. A response stays on `rsp_valid`/`rsp_data`, unchanged, until an edge where `rsp_ready` is high. A new hit can be accepted on that same edge. Writes produce no response.

Top module: `multibank_rowcache`

## Requirements
- R1: `req_addr` is `{bank, row, col}`: the top log2(NBANK) bits pick one of NBANK (4) independent banks, the next log2(NROW) bits give the row compared with that bank's tag, and the low log2(NCOL) bits give the word inside the row.
- R2: After reset every bank tag is invalid, `req_ready` is 1, `rsp_valid` and `refresh_ack` are 0, `refresh_ptr` is 0, and the first read to each bank is a miss.
- R3: A read whose row equals the valid tag of its bank is a hit: `rsp_valid` rises in the cycle right after the accepting edge, carrying the word from the row register.
- R4: A read miss loads the entire row into the bank's row register and sets its tag. `rsp_valid` rises three cycles after the accepting edge, with `req_ready` low in between. Later reads of any column of that row are hits.
- R5: A fill in one bank leaves the row registers and tags of the other banks untouched, so their cached rows still hit.
- R6: A write is accepted in one cycle whether it hits or misses. It creates no response and leaves `req_ready` high, so writes can follow back to back.
- R7: A write to a cached row updates the row register at once, so an immediate read returns the new word with hit latency. Every write also reaches the array, so a later miss to that row, including one issued on the very next cycle, returns the written data. A write does not change any tag.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold and `req_ready` is low. A request held during the stall is accepted on the edge where the response is taken.
- R9: Each `refresh_req` pulse causes exactly one refresh lasting REF_CYC cycles. It ends with a one-cycle `refresh_ack` and advances `refresh_ptr` by one, wrapping over all NBANK*NROW rows. Hit reads keep their one-cycle latency while it runs.
- R10: A refresh requested during a miss fill starts only after the fill has completed and leaves the fill's latency at three. A miss accepted while a refresh runs is returned correctly after the refresh ends. No refresh invalidates a row register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | log2(NBANK)+log2(NROW)+log2(NCOL) | `{bank, row, col}` |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Requester takes the read data |
| rsp_data | output | DATA_W | Read data |
| refresh_req | input | 1 | One-cycle pulse asking for one refresh |
| refresh_ack | output | 1 | One-cycle pulse when a refresh completes |
| refresh_ptr | output | log2(NBANK)+log2(NROW) | Next row the refresh counter will refresh |

## Verification
The bench builds the block with NBANK=4, NROW=8, NCOL=16, DATA_W=32, MISS_LAT=3 and REF_CYC=6. The array then has only 32 rows, so conflicting rows in one bank are easy to reach and eviction, refill and write-back to the array can all be shown in a short vector table. The six-cycle refresh window is long enough for several hit reads to complete inside it. It also gives a miss issued during a refresh a measurable stall, and lets a refresh requested mid-fill be seen to wait for the fill.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/rcd_bank.sv
module rcd_bank #(
  parameter int DATA_W = 32,
  parameter int NCOL   = 16,
  parameter int ROW_W  = 3,
  localparam int COL_W = $clog2(NCOL),
  localparam int LINE_BITS = DATA_W * NCOL
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROW_W-1:0]     cmp_row,
  input  logic [COL_W-1:0]     col,
  output logic                 hit,
  output logic [DATA_W-1:0]    rd_word,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_word,
  input  logic                 fill_en,
  input  logic [ROW_W-1:0]     fill_row,
  input  logic [LINE_BITS-1:0] fill_line
);
  logic              tag_vld;
  logic [ROW_W-1:0]  tag;
  logic [DATA_W-1:0] words [NCOL];

  assign hit     = tag_vld && (tag == cmp_row);
  assign rd_word = words[col];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_vld <= 1'b0;
      tag     <= '0;
    end else if (fill_en) begin
      tag_vld <= 1'b1;
      tag     <= fill_row;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      for (int c = 0; c < NCOL; c++) begin
        words[c] <= fill_line[c*DATA_W +: DATA_W];
      end
    end else if (wr_en && hit) begin
      words[col] <= wr_word;
    end
  end

  // R4
  fill_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (tag_vld && tag == $past(fill_row)));

  // R7
  write_keeps_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fill_en) |=> ($stable(tag) && $stable(tag_vld)));
endmodule

// File: rtl/rcd_dram.sv
module rcd_dram #(
  parameter int DATA_W = 32,
  parameter int NCOL   = 16,
  parameter int LINES  = 32,
  localparam int COL_W = $clog2(NCOL),
  localparam int IDX_W = $clog2(LINES),
  localparam int LINE_BITS = DATA_W * NCOL
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [COL_W-1:0]     wr_col,
  input  logic [DATA_W-1:0]    wr_word,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [LINE_BITS-1:0] rd_line,
  input  logic                 restore_en,
  input  logic [IDX_W-1:0]     restore_idx
);
  logic [LINE_BITS-1:0] cells [LINES];

  assign rd_line = cells[rd_idx];

  always_ff @(posedge clk) begin
    if (restore_en) begin
      cells[restore_idx] <= cells[restore_idx];
    end
    if (wr_en) begin
      cells[wr_idx][wr_col*DATA_W +: DATA_W] <= wr_word;
    end
  end
endmodule

// File: rtl/rcd_refresh.sv
module rcd_refresh #(
  parameter int REF_CYC = 4,
  parameter int LINES   = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int CYC_W  = $clog2(REF_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             allow,
  output logic             busy,
  output logic             ack,
  output logic             restore_en,
  output logic [IDX_W-1:0] ptr
);
  logic             pend;
  logic             start;
  logic [CYC_W-1:0] cyc;
  logic             last;

  assign start      = pend && allow && !busy;
  assign last       = busy && (cyc == CYC_W'(REF_CYC - 1));
  assign restore_en = last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      busy <= 1'b0;
      cyc  <= '0;
      ack  <= 1'b0;
      ptr  <= '0;
    end else begin
      ack  <= 1'b0;
      pend <= (pend && !start) || req;
      if (start) begin
        busy <= 1'b1;
        cyc  <= '0;
      end else if (last) begin
        busy <= 1'b0;
        ack  <= 1'b1;
        ptr  <= (ptr == IDX_W'(LINES - 1)) ? '0 : ptr + IDX_W'(1);
      end else if (busy) begin
        cyc <= cyc + CYC_W'(1);
      end
    end
  end

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> (ack || $stable(ptr)));
endmodule

// File: rtl/multibank_rowcache.sv
module multibank_rowcache
  import rcd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NBANK    = 4,
  parameter int NROW     = 8,
  parameter int NCOL     = 16,
  parameter int MISS_LAT = 3,
  parameter int REF_CYC  = 4,
  localparam int BANK_W  = $clog2(NBANK),
  localparam int ROW_W   = $clog2(NROW),
  localparam int COL_W   = $clog2(NCOL),
  localparam int ADDR_W  = BANK_W + ROW_W + COL_W,
  localparam int IDX_W   = BANK_W + ROW_W,
  localparam int LINES   = NBANK * NROW,
  localparam int LINE_BITS = DATA_W * NCOL,
  localparam int CNT_W   = $clog2(MISS_LAT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              refresh_req,
  output logic              refresh_ack,
  output logic [IDX_W-1:0]  refresh_ptr
);
  logic [BANK_W-1:0] a_bank;
  logic [ROW_W-1:0]  a_row;
  logic [COL_W-1:0]  a_col;

  assign a_bank = req_addr[ADDR_W-1 -: BANK_W];
  assign a_row  = req_addr[COL_W +: ROW_W];
  assign a_col  = req_addr[COL_W-1:0];

  ctl_state_e        state;
  logic [BANK_W-1:0] f_bank;
  logic [ROW_W-1:0]  f_row;
  logic [COL_W-1:0]  f_col;
  logic [CNT_W-1:0]  cnt;

  logic              post_vld;
  logic [IDX_W-1:0]  post_idx;
  logic [COL_W-1:0]  post_col;
  logic [DATA_W-1:0] post_data;

  logic [NBANK-1:0]  hit_vec;
  logic [DATA_W-1:0] bank_rd [NBANK];
  logic [LINE_BITS-1:0] dram_line;

  logic ref_busy;
  logic ref_restore;
  logic sel_hit, acc, acc_rd, acc_wr, fill_go;

  assign sel_hit   = hit_vec[a_bank];
  assign req_ready = (state == ST_IDLE) && (!rsp_valid || rsp_ready);
  assign acc       = req_valid && req_ready;
  assign acc_rd    = acc && !req_write;
  assign acc_wr    = acc && req_write;
  assign fill_go   = (state == ST_FILL) && !ref_busy && (cnt == CNT_W'(MISS_LAT - 2));

  generate
    for (genvar i = 0; i < NBANK; i++) begin : g_bank
      rcd_bank #(
        .DATA_W (DATA_W),
        .NCOL   (NCOL),
        .ROW_W  (ROW_W)
      ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_row   (a_row),
        .col       (a_col),
        .hit       (hit_vec[i]),
        .rd_word   (bank_rd[i]),
        .wr_en     (acc_wr && (a_bank == BANK_W'(i))),
        .wr_word   (req_wdata),
        .fill_en   (fill_go && (f_bank == BANK_W'(i))),
        .fill_row  (f_row),
        .fill_line (dram_line)
      );
    end
  endgenerate

  rcd_dram #(
    .DATA_W (DATA_W),
    .NCOL   (NCOL),
    .LINES  (LINES)
  ) u_dram (
    .clk         (clk),
    .wr_en       (post_vld),
    .wr_idx      (post_idx),
    .wr_col      (post_col),
    .wr_word     (post_data),
    .rd_idx      ({f_bank, f_row}),
    .rd_line     (dram_line),
    .restore_en  (ref_restore),
    .restore_idx (refresh_ptr)
  );

  rcd_refresh #(
    .REF_CYC (REF_CYC),
    .LINES   (LINES)
  ) u_refresh (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (refresh_req),
    .allow      (state == ST_IDLE),
    .busy       (ref_busy),
    .ack        (refresh_ack),
    .restore_en (ref_restore),
    .ptr        (refresh_ptr)
  );

  // write posting register: drains to the array one edge after acceptance
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_vld  <= 1'b0;
      post_idx  <= '0;
      post_col  <= '0;
      post_data <= '0;
    end else begin
      post_vld <= acc_wr;
      if (acc_wr) begin
        post_idx  <= {a_bank, a_row};
        post_col  <= a_col;
        post_data <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      f_bank    <= '0;
      f_row     <= '0;
      f_col     <= '0;
      cnt       <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (acc_rd) begin
            if (sel_hit) begin
              rsp_valid <= 1'b1;
              rsp_data  <= bank_rd[a_bank];
            end else begin
              state  <= ST_FILL;
              f_bank <= a_bank;
              f_row  <= a_row;
              f_col  <= a_col;
              cnt    <= '0;
            end
          end
        end
        ST_FILL: begin
          if (fill_go) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_data  <= dram_line[f_col*DATA_W +: DATA_W];
          end else if (!ref_busy) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && sel_hit) |=> rsp_valid);

  // R4
  miss_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !sel_hit) |=> !rsp_valid);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R10
  refresh_waits_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL) |=> !$rose(ref_busy));
endmodule

// File: tb/multibank_rowcache_test.sv
module multibank_rowcache_test;
  localparam int DW = 32;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic          refresh_req = 1'b0;
  logic          refresh_ack;
  logic [4:0]    refresh_ptr;

  always #5 clk = ~clk;

  multibank_rowcache #(
    .DATA_W (32), .NBANK (4), .NROW (8), .NCOL (16),
    .MISS_LAT (3), .REF_CYC (6)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_data (rsp_data),
    .refresh_req (refresh_req), .refresh_ack (refresh_ack), .refresh_ptr (refresh_ptr)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int ack_cnt = 0;
  int ack_cyc = 0;
  int rsp_cyc = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (refresh_ack) begin
      ack_cnt++;
      ack_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // {wr, bank, row, col, data, lat}; lat 0 marks a write
  localparam logic [43:0] VEC [17] = '{
    {1'b1, 2'd0, 3'd1, 4'd2,  32'h0000_00A1, 2'd0},
    {1'b1, 2'd0, 3'd1, 4'd5,  32'h0000_00A2, 2'd0},
    {1'b1, 2'd1, 3'd3, 4'd0,  32'h0000_00B1, 2'd0},
    {1'b1, 2'd2, 3'd7, 4'd15, 32'h0000_00C1, 2'd0},
    {1'b0, 2'd0, 3'd1, 4'd2,  32'h0000_00A1, 2'd3},
    {1'b0, 2'd0, 3'd1, 4'd5,  32'h0000_00A2, 2'd1},
    {1'b0, 2'd1, 3'd3, 4'd0,  32'h0000_00B1, 2'd3},
    {1'b0, 2'd0, 3'd1, 4'd2,  32'h0000_00A1, 2'd1},
    {1'b1, 2'd0, 3'd1, 4'd5,  32'h0000_00A3, 2'd0},
    {1'b0, 2'd0, 3'd1, 4'd5,  32'h0000_00A3, 2'd1},
    {1'b1, 2'd1, 3'd4, 4'd0,  32'h0000_00D1, 2'd0},
    {1'b0, 2'd1, 3'd3, 4'd0,  32'h0000_00B1, 2'd1},
    {1'b0, 2'd1, 3'd4, 4'd0,  32'h0000_00D1, 2'd3},
    {1'b0, 2'd1, 3'd3, 4'd0,  32'h0000_00B1, 2'd3},
    {1'b0, 2'd2, 3'd7, 4'd15, 32'h0000_00C1, 2'd3},
    {1'b1, 2'd3, 3'd0, 4'd1,  32'h0000_00E1, 2'd0},
    {1'b0, 2'd3, 3'd0, 4'd1,  32'h0000_00E1, 2'd3}
  };

  task automatic do_write(input logic [1:0] b, input logic [2:0] r, input logic [3:0] c,
                          input logic [31:0] d, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = {b, r, c}; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(req_ready == 1'b1, req, "ready after write", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, req, "no response to write", 32'(rsp_valid), 32'd0);
  endtask

  // exp_lat 0: latency must exceed 3
  task automatic do_read(input logic [1:0] b, input logic [2:0] r, input logic [3:0] c,
                         input logic [31:0] d, input int exp_lat, input string req);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {b, r, c};
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    rsp_cyc = cyc;
    if (exp_lat == 0)
      chk(lat > 3, req, "stalled read latency", 32'(lat), 32'd4);
    else
      chk(lat == exp_lat, req, "read latency", 32'(lat), 32'(exp_lat));
    chk(rsp_data == d, req, "read data", rsp_data, d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    chk(req_ready == 1'b1, "R2", "req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R2", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk(refresh_ack == 1'b0, "R2", "refresh_ack", 32'(refresh_ack), 32'd0);
    chk(refresh_ptr == 5'd0, "R2", "refresh_ptr", 32'(refresh_ptr), 32'd0);

    // table walk: R1 R3 R4 R5 R6 R7 (first reads of each bank are misses: R2)
    for (int i = 0; i < 17; i++) begin
      if (VEC[i][43])
        do_write(VEC[i][42:41], VEC[i][40:38], VEC[i][37:34], VEC[i][33:2], "R6/R7");
      else
        do_read(VEC[i][42:41], VEC[i][40:38], VEC[i][37:34], VEC[i][33:2],
                int'(VEC[i][1:0]), "R1/R3/R4/R5/R7");
    end

    // R8 back-pressure, with a second hit waiting during the stall
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = {2'd0, 3'd1, 4'd2};
    @(posedge clk);
    @(negedge clk);
    req_addr = {2'd1, 3'd3, 4'd0};
    chk(rsp_valid == 1'b1, "R3", "stalled rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rsp_data == 32'hA1, "R3", "stalled rsp_data", rsp_data, 32'hA1);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(rsp_valid == 1'b1, "R8", "held rsp_valid", 32'(rsp_valid), 32'd1);
      chk(rsp_data == 32'hA1, "R8", "held rsp_data", rsp_data, 32'hA1);
      chk(req_ready == 1'b0, "R8", "req_ready in stall", 32'(req_ready), 32'd0);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R8", "next hit after release", 32'(rsp_valid), 32'd1);
    chk(rsp_data == 32'hB1, "R8", "next hit data", rsp_data, 32'hB1);

    // R9 refresh with hits running inside it
    @(negedge clk);
    refresh_req = 1'b1;
    @(negedge clk);
    refresh_req = 1'b0;
    do_read(2'd1, 3'd3, 4'd0, 32'hB1, 1, "R9");
    do_read(2'd2, 3'd7, 4'd15, 32'hC1, 1, "R9");
    do_read(2'd3, 3'd0, 4'd1, 32'hE1, 1, "R9");
    repeat (15) @(negedge clk);
    chk(ack_cnt == 1, "R9", "ack pulses", 32'(ack_cnt), 32'd1);
    chk(refresh_ptr == 5'd1, "R9", "refresh_ptr", 32'(refresh_ptr), 32'd1);

    // R10 refresh asked during a fill waits for it
    do_write(2'd2, 3'd5, 4'd3, 32'h0000_00F1, "R6");
    fork
      do_read(2'd2, 3'd5, 4'd3, 32'h0000_00F1, 3, "R10");
      begin
        @(negedge clk);
        @(negedge clk);
        refresh_req = 1'b1;
        @(negedge clk);
        refresh_req = 1'b0;
      end
    join
    repeat (15) @(negedge clk);
    chk(ack_cnt == 2, "R10", "ack after fill", 32'(ack_cnt), 32'd2);
    chk(ack_cyc > rsp_cyc, "R10", "ack cycle after response", 32'(ack_cyc), 32'(rsp_cyc + 1));
    do_read(2'd2, 3'd5, 4'd3, 32'h0000_00F1, 1, "R10");
    do_read(2'd0, 3'd1, 4'd2, 32'h0000_00A1, 1, "R10");

    // R10 miss that arrives while a refresh runs
    do_write(2'd1, 3'd6, 4'd9, 32'h0000_0061, "R6");
    @(negedge clk);
    refresh_req = 1'b1;
    @(negedge clk);
    refresh_req = 1'b0;
    do_read(2'd1, 3'd6, 4'd9, 32'h0000_0061, 0, "R10");
    repeat (10) @(negedge clk);
    chk(ack_cnt == 3, "R9", "third refresh", 32'(ack_cnt), 32'd3);
    chk(refresh_ptr == 5'd3, "R9", "refresh_ptr step", 32'(refresh_ptr), 32'd3);
    do_read(2'd3, 3'd0, 4'd1, 32'hE1, 1, "R10");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule